// File: doc/BRIEF.md
# Word Load/Store Execution Unit

This block carries out one word-sized memory instruction at a time. A 32-bit instruction word arrives with a valid strobe. The block decodes it and reads two entries of its own 32-entry register file: the base and the data register. It adds the sign-extended 16-bit offset to the base value to get a byte address. In the same cycle it drives a synchronous, word-wide memory port.

A load returns its word on the following cycle, and the block writes that word into the data register at the end of the cycle. A store writes the data register to memory at the first clock edge. If the computed address is not word aligned, the block makes no memory access and changes no register. It reports an alignment error instead. Every instruction ends with a one-cycle completion pulse.

The controller is a five-state machine:
- **IDLE** waits for the strobe. On a strobe it goes to one of the other four states:
  - **LOAD_WB** for an aligned load.
  - **STORE_ACK** for an aligned store.
  - **ALIGN_FAULT** for a load or store whose address is misaligned.
  - **NOP_ACK** for any other opcode.
- Each of the four completion states returns to IDLE after one cycle.

Top module: `lsu_word_exec`

## Requirements
- R1: Instruction bits [31:26] equal to 100011 select a word load and 101011 select a word store. Bits [25:21] name the base register, bits [20:16] name the data register and bits [15:0] hold the offset.
- R2: The effective address is the 32-bit base register value plus the offset sign-extended from bit 15. For example, 0x8FFF adds 0xFFFF8FFF. The address is presented on `mem_addr` in the strobe cycle.
- R3: An aligned load reads memory at the effective address (`mem_en`=1, `mem_we`=0). The data register receives `mem_rdata` at the end of the completion cycle.
- R4: An aligned store raises `mem_en` and `mem_we` in the strobe cycle, with the data register value on `mem_wdata`.
- R5: Memory is byte addressed and little-endian. Data bits [7:0] belong to the effective address and bits [31:24] to the effective address plus 3.
- R6: An address whose low two bits are not 00 makes no memory access and writes no register. It raises `align_err` together with `done`.
- R7: Register 0 always reads as zero. A load into register 0 has no effect.
- R8: `done` is high for exactly one cycle, the cycle after an accepted strobe.
- R9: A strobe that arrives while `done` is high is ignored. It makes no memory access and no register write.
- R10: Any other opcode makes no memory access and no register write. It completes with `done` high and `align_err` low.
- R11: During reset `done`, `align_err` and `mem_en` are low. All registers read as zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction strobe |
| instr_word | input | 32 | Instruction being issued |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Store data, little-endian lanes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| done | output | 1 | Instruction completion pulse |
| align_err | output | 1 | Misaligned address reported |

## Verification
The bound checker checks these rules on every cycle:
- Each memory request is followed by a single-cycle `done`.
- No request is made while `done` is high.
- Every request carries an aligned address, and a write only ever comes with an enable.
- An alignment error never follows a request.

Only the bench scenarios can show whether the values are right: the sign-extended address sum, the little-endian byte placement, register 0 staying zero, and the register file contents after loads. To show these, the bench stores registers back out and compares a byte-level memory image against its own model.

// File: rtl/lsu_word_pkg.sv
package lsu_word_pkg;
    localparam int INSTR_W  = 32;
    localparam int IDX_W    = 5;
    localparam int OFFS_W   = 16;
    localparam logic [5:0] OPC_LOAD_WORD  = 6'b100011;
    localparam logic [5:0] OPC_STORE_WORD = 6'b101011;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_LOAD,
        KIND_STORE
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [IDX_W-1:0]  base_idx;
        logic [IDX_W-1:0]  data_idx;
        logic [OFFS_W-1:0] offset;
    } dec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_WB,
        ST_STORE_ACK,
        ST_ALIGN_FAULT,
        ST_NOP_ACK
    } state_e;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_word_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [5:0] opc;

    always_comb begin
        opc          = instr[31:26];
        dec.base_idx = instr[25:21];
        dec.data_idx = instr[20:16];
        dec.offset   = instr[15:0];
        if (opc == OPC_LOAD_WORD) begin
            dec.kind = KIND_LOAD;
        end else if (opc == OPC_STORE_WORD) begin
            dec.kind = KIND_STORE;
        end else begin
            dec.kind = KIND_NONE;
        end
    end
endmodule

// File: rtl/lsu_regfile.sv
module lsu_regfile #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 32,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [AW-1:0]     rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    logic [NREGS-1:0][DATA_W-1:0] regs;

    for (genvar i = 0; i < NREGS; i++) begin : g_entry
        if (i == 0) begin : g_zero
            assign regs[i] = '0;
        end else begin : g_flop
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && wr_idx == AW'(i)) begin
                    q <= wr_data;
                end
            end
            assign regs[i] = q;
        end
    end

    assign rd_a_data = regs[rd_a_idx];
    assign rd_b_data = regs[rd_b_idx];
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen #(
    parameter int DATA_W = 32,
    parameter int OFFS_W = 16,
    localparam int LOW_W = $clog2(DATA_W / 8)
) (
    input  logic [DATA_W-1:0] base,
    input  logic [OFFS_W-1:0] offset,
    output logic [DATA_W-1:0] eff_addr,
    output logic              misaligned
);
    logic [DATA_W-1:0] offs_ext;

    always_comb begin
        offs_ext   = {{(DATA_W - OFFS_W){offset[OFFS_W-1]}}, offset};
        eff_addr   = base + offs_ext;
        misaligned = (eff_addr[LOW_W-1:0] != '0);
    end
endmodule

// File: rtl/lsu_word_exec.sv
module lsu_word_exec
    import lsu_word_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREGS  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              mem_en,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              align_err
);
    localparam int AW = $clog2(NREGS);

    state_e            state_q, state_d;
    dec_t              dec;
    logic [DATA_W-1:0] base_val, data_val, eff_addr;
    logic              misaligned;
    logic [AW-1:0]     wb_idx_q;
    logic              rf_we;
    logic              accept;

    lsu_decode u_dec (
        .instr (instr_word),
        .dec   (dec)
    );

    lsu_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (AW'(dec.base_idx)),
        .rd_a_data (base_val),
        .rd_b_idx  (AW'(dec.data_idx)),
        .rd_b_data (data_val),
        .wr_en     (rf_we),
        .wr_idx    (wb_idx_q),
        .wr_data   (mem_rdata)
    );

    lsu_agen #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_agen (
        .base       (base_val),
        .offset     (dec.offset),
        .eff_addr   (eff_addr),
        .misaligned (misaligned)
    );

    assign accept = (state_q == ST_IDLE) && instr_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            wb_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                wb_idx_q <= AW'(dec.data_idx);
            end
        end
    end

    // next-state selection
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_valid) begin
                    if (dec.kind == KIND_NONE) begin
                        state_d = ST_NOP_ACK;
                    end else if (misaligned) begin
                        state_d = ST_ALIGN_FAULT;
                    end else if (dec.kind == KIND_LOAD) begin
                        state_d = ST_LOAD_WB;
                    end else begin
                        state_d = ST_STORE_ACK;
                    end
                end
            end
            ST_LOAD_WB, ST_STORE_ACK, ST_ALIGN_FAULT, ST_NOP_ACK: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = eff_addr;
        mem_wdata = data_val;
        done      = 1'b0;
        align_err = 1'b0;
        rf_we     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_valid && !misaligned && dec.kind != KIND_NONE) begin
                    mem_en = 1'b1;
                    mem_we = (dec.kind == KIND_STORE);
                end
            end
            ST_LOAD_WB: begin
                done  = 1'b1;
                rf_we = 1'b1;
            end
            ST_STORE_ACK, ST_NOP_ACK: done = 1'b1;
            ST_ALIGN_FAULT: begin
                done      = 1'b1;
                align_err = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lsu_word_exec_chk.sv
module lsu_word_exec_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic              mem_en,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic              done,
    input logic              align_err
);
    localparam int LOW_W = $clog2(DATA_W / 8);

    a_r8_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> done);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_no_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_en);

    a_r5_aligned_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr[LOW_W-1:0] == '0));

    a_r4_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    a_r6_fault_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (done && !$past(mem_en)));

    a_r8_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(instr_valid));
endmodule

bind lsu_word_exec lsu_word_exec_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .done        (done),
    .align_err   (align_err)
);

// File: tb/sim_lsu_word_exec.sv
`timescale 1ns/1ps
module sim_lsu_word_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        mem_en, mem_we, done, align_err;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int failures = 0;

    logic [7:0]  ram     [256];
    logic [7:0]  exp_mem [256];
    logic [31:0] exp_reg [32];
    logic [31:0] last_addr;

    always #2 clk = ~clk;

    lsu_word_exec u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done), .align_err(align_err)
    );

    // synchronous byte-addressed memory model, little-endian lanes
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++) ram[8'(mem_addr[7:0] + 8'(b))] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= {ram[8'(mem_addr[7:0] + 8'd3)], ram[8'(mem_addr[7:0] + 8'd2)],
                              ram[8'(mem_addr[7:0] + 8'd1)], ram[mem_addr[7:0]]};
            end
        end
    end

    function automatic logic [31:0] mk(input logic [5:0] op, input int rs, input int rt,
                                       input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] sext16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] exp_word(input logic [7:0] a);
        return {exp_mem[8'(a + 8'd3)], exp_mem[8'(a + 8'd2)], exp_mem[8'(a + 8'd1)], exp_mem[a]};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] ins);
        logic [5:0]  op;
        logic        is_ld, is_st, mis;
        logic [31:0] ea;
        int          rs, rt;
        op    = ins[31:26];
        rs    = int'(ins[25:21]);
        rt    = int'(ins[20:16]);
        is_ld = (op == 6'b100011);
        is_st = (op == 6'b101011);
        ea    = exp_reg[rs] + sext16(ins[15:0]);
        mis   = (is_ld || is_st) && (ea[1:0] != 2'b00);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = ins;
        #1;
        last_addr = mem_addr;
        chk(mis ? "R6" : "R1", "mem_en", 32'(mem_en), 32'((is_ld || is_st) && !mis));
        if ((is_ld || is_st) && !mis) begin
            chk("R2", "mem_addr", mem_addr, ea);
            chk(is_st ? "R4" : "R3", "mem_we", 32'(mem_we), 32'(is_st));
            if (is_st) chk("R4", "mem_wdata", mem_wdata, exp_reg[rt]);
        end
        @(negedge clk);
        instr_valid = 1'b0;
        #1;
        chk("R8", "done", 32'(done), 32'd1);
        chk(mis ? "R6" : "R10", "align_err", 32'(align_err), 32'(mis));
        if (!mis && is_st) begin
            for (int b = 0; b < 4; b++) exp_mem[8'(ea[7:0] + 8'(b))] = exp_reg[rt][8*b +: 8];
        end
        if (!mis && is_ld && rt != 0) exp_reg[rt] = exp_word(ea[7:0]);
        @(negedge clk);
        #1;
        chk("R8", "done low", 32'(done), 32'd0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        for (int i = 0; i < 256; i++) begin
            ram[i]     = 8'($urandom);
            exp_mem[i] = ram[i];
        end
        ram[8'h20] = 8'h01; ram[8'h21] = 8'h80; ram[8'h22] = 8'h00; ram[8'h23] = 8'h00;
        for (int i = 8'h20; i < 8'h24; i++) exp_mem[i] = ram[i];
        for (int i = 0; i < 32; i++) exp_reg[i] = '0;

        // R11 reset state
        repeat (3) @(negedge clk);
        chk("R11", "done in reset", 32'(done), 32'd0);
        chk("R11", "align_err in reset", 32'(align_err), 32'd0);
        chk("R11", "mem_en in reset", 32'(mem_en), 32'd0);
        rst_n = 1'b1;

        // R11 registers zero after reset: store r7 shows zero
        run(mk(6'b101011, 0, 7, 16'h0010));
        chk("R11", "reg after reset", {ram[8'h13], ram[8'h12], ram[8'h11], ram[8'h10]}, 32'd0);

        // R3/R5 little-endian load, then store it back
        run(mk(6'b100011, 0, 1, 16'h0020));
        run(mk(6'b101011, 0, 1, 16'h0030));
        chk("R5", "byte at base", 32'(ram[8'h30]), 32'h01);
        chk("R5", "byte at base+1", 32'(ram[8'h31]), 32'h80);
        chk("R3", "loaded word", {ram[8'h33], ram[8'h32], ram[8'h31], ram[8'h30]}, 32'h0000_8001);

        // R2 sign extension: 0x8001 + 0xFFFF8FFF = 0x00001000
        run(mk(6'b100011, 1, 2, 16'h8FFF));
        chk("R2", "sign-extended address", last_addr, 32'h0000_1000);

        // R6 misaligned load and store leave state untouched
        run(mk(6'b100011, 1, 3, 16'h0000));
        run(mk(6'b101011, 0, 3, 16'h0040));
        chk("R6", "misaligned load wrote reg", {ram[8'h43], ram[8'h42], ram[8'h41], ram[8'h40]}, 32'd0);
        run(mk(6'b101011, 1, 1, 16'h0001));
        chk("R6", "misaligned store byte", 32'(ram[8'h02]), 32'(exp_mem[8'h02]));

        // R7 register zero ignores loads
        run(mk(6'b100011, 0, 0, 16'h0020));
        run(mk(6'b101011, 0, 0, 16'h0034));
        chk("R7", "r0 after load", {ram[8'h37], ram[8'h36], ram[8'h35], ram[8'h34]}, 32'd0);

        // R10 other opcode
        run(mk(6'b001000, 1, 4, 16'h0004));

        // R9 strobe in the done cycle is ignored
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = mk(6'b101011, 0, 1, 16'h0080);
        @(negedge clk);
        instr_word = mk(6'b101011, 0, 1, 16'h0084);
        #1;
        chk("R9", "mem_en while busy", 32'(mem_en), 32'd0);
        chk("R9", "done while busy", 32'(done), 32'd1);
        for (int b = 0; b < 4; b++) exp_mem[8'h80 + b] = exp_reg[1][8*b +: 8];
        @(negedge clk);
        instr_valid = 1'b0;
        #1;
        chk("R9", "ignored store bytes", {ram[8'h87], ram[8'h86], ram[8'h85], ram[8'h84]},
            exp_word(8'h84));

        // constrained random mix (R1..R7, R10)
        for (int n = 0; n < 400; n++) begin
            logic [5:0]  op;
            logic [15:0] imm;
            int          rs, rt, sel;
            sel = int'($urandom_range(0, 99));
            op  = (sel < 45) ? 6'b100011 : (sel < 90) ? 6'b101011 : 6'($urandom);
            rs  = int'($urandom_range(0, 31));
            rt  = int'($urandom_range(0, 31));
            imm = 16'($urandom);
            if ($urandom_range(0, 9) < 8) imm[1:0] = 2'(-exp_reg[rs][1:0]);
            run(mk(op, rs, rt, imm));
        end

        // sweep every register out and compare the memory image
        for (int r = 1; r < 32; r++) run(mk(6'b101011, 0, r, 16'h00C0));
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 256; i++) if (ram[i] !== exp_mem[i]) bad++;
            chk("R4", "memory image mismatches", 32'(bad), 32'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule